// File: doc/BRIEF.md
# Watermark Conversion and Commit Bank

This block keeps the latency watermarks that a memory request arbiter compares against. There are four selectable watermark sets, and each set has five values: data urgency, page-table/metadata urgency, self-refresh entry, self-refresh exit and DRAM clock switch. Software writes one watermark at a time, given in nanoseconds, together with a set and a field index. The block multiplies the value by the reference clock frequency in MHz and divides it by 1000. It clamps the result to the 21-bit field maximum, so a large value never wraps. The result goes into a shadow bank.

The arbiter never sees the shadow bank. A rising edge on the change-request input copies every shadow value into the active bank in one cycle, and a one-cycle done pulse follows. The same commit latches three arbiter controls: a saturation level equal to 60 times the reference clock, a minimum-outstanding-request count of 68, and the self-refresh force controls. A combinational read port returns any active value. A build parameter removes the two self-refresh fields. In that configuration they read as zero and writes to them are dropped.

Top module: `wm_bank`

## Requirements
- R1: After reset every active value reads 0, `wr_ready` is 1, `chg_done` is 0, and `sat_level`, `min_outstanding` and `sr_force_en` are 0.
- R2: A stored watermark equals floor(`wr_ns` × `refclk_mhz` / 1000). The product is formed at full 32-bit width.
- R3: A converted result above 0x1FFFFF is stored as 0x1FFFFF. A result at or below it is stored unchanged.
- R4: `wr_set`/`rd_set` value 0..3 selects set A..D. Field codes are 0 data urgency, 1 page-table/metadata urgency, 2 self-refresh enter, 3 self-refresh exit and 4 DRAM clock change. A write with field code 5..7 is dropped and changes no stored value, and a read with such a code returns 0.
- R5: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 for the following cycle, so at most one conversion is in flight. The shadow value is updated on the second edge after acceptance.
- R6: Shadow writes do not change the read port until a commit.
- R7: A 0-to-1 transition of `chg_req`, seen at a clock edge, copies all shadow values to the active bank on that edge. Holding `chg_req` high commits nothing further.
- R8: `chg_done` is high for exactly one cycle, starting one cycle after the copy becomes visible.
- R9: With `HAS_SR` = 0, fields 2 and 3 read 0 and writes to them are dropped.
- R10: On commit, `sat_level` takes 60 × `refclk_mhz` and `min_outstanding` takes 68. Both hold these values until the next commit.
- R11: On commit, `sr_force_en` takes the value of `stutter_off`. `sr_force_val` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refclk_mhz | input | 12 | Reference clock frequency in MHz |
| stutter_off | input | 1 | Requests self-refresh force enable at the next commit |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Converter can accept a write |
| wr_set | input | 2 | Set index of the write |
| wr_field | input | 3 | Field code of the write |
| wr_ns | input | 20 | Watermark in nanoseconds |
| chg_req | input | 1 | Change request; a rising edge commits |
| chg_done | output | 1 | One-cycle pulse after a commit |
| rd_set | input | 2 | Set index of the read |
| rd_field | input | 3 | Field code of the read |
| rd_data | output | 21 | Active watermark in reference clock cycles |
| sat_level | output | 18 | Latched arbiter saturation level |
| min_outstanding | output | 7 | Latched minimum outstanding request count |
| sr_force_en | output | 1 | Latched self-refresh force enable |
| sr_force_val | output | 1 | Self-refresh force value, always 0 |

## Verification
The conversion is driven with a zero value, with small values whose quotient truncates to zero or loses a fraction, and with an odd reference frequency. Together these separate a floor divide from rounding and from a wrong divisor. A product far above the field limit and one just below it show that saturation clamps rather than wraps, and that values under the limit are not touched. Distinct values are written into every field of one set, and an invalid field code is written whose flat index would alias the next set. These show the set and field decoding and that invalid codes are dropped. Writes made before a commit, writes made while the request is held high, and a second rising edge show that updates are staged and taken only on the edge. A second instance built without self-refresh fields gets the same stimulus and shows that those fields read 0.

// File: rtl/wm_bank.sv
module wm_bank #(
  parameter int SETS     = 4,
  parameter int FIELDS   = 5,
  parameter int NS_W     = 20,
  parameter int MHZ_W    = 12,
  parameter int WM_W     = 21,
  parameter int SAT_W    = 18,
  parameter int OUT_W    = 7,
  parameter int SAT_MULT = 60,
  parameter int MIN_OUT  = 68,
  parameter int HAS_SR   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MHZ_W-1:0] refclk_mhz,
  input  logic             stutter_off,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [1:0]       wr_set,
  input  logic [2:0]       wr_field,
  input  logic [NS_W-1:0]  wr_ns,
  input  logic             chg_req,
  output logic             chg_done,
  input  logic [1:0]       rd_set,
  input  logic [2:0]       rd_field,
  output logic [WM_W-1:0]  rd_data,
  output logic [SAT_W-1:0] sat_level,
  output logic [OUT_W-1:0] min_outstanding,
  output logic             sr_force_en,
  output logic             sr_force_val
);
  localparam int PROD_W  = NS_W + MHZ_W;
  localparam int ENTRIES = SETS * FIELDS;
  localparam int F_SR_IN = 2;
  localparam int F_SR_EX = 3;
  localparam logic [WM_W-1:0]   WM_MAX  = '1;
  localparam logic [PROD_W-1:0] DIVISOR = PROD_W'(1000);

  logic [WM_W-1:0]   shadow_q [ENTRIES];
  logic [WM_W-1:0]   active_q [ENTRIES];
  logic              p1_valid;
  logic [PROD_W-1:0] p1_prod;
  logic [1:0]        p1_set;
  logic [2:0]        p1_field;
  logic              req_q, commit_q, done_q;
  logic [SAT_W-1:0]  sat_q;
  logic [OUT_W-1:0]  minout_q;
  logic              force_q;

  function automatic logic slot_ok(input logic [1:0] s, input logic [2:0] f);
    int fi;
    fi = int'(f);
    return (int'(s) < SETS) && (fi < FIELDS) &&
           ((HAS_SR != 0) || ((fi != F_SR_IN) && (fi != F_SR_EX)));
  endfunction

  function automatic int slot(input logic [1:0] s, input logic [2:0] f);
    return int'(s) * FIELDS + int'(f);
  endfunction

  logic accept, commit;
  logic [PROD_W-1:0] quot;
  logic [WM_W-1:0]   wm_sat;

  assign wr_ready = !p1_valid;
  assign accept   = wr_valid && wr_ready;
  assign commit   = chg_req && !req_q;
  assign quot     = p1_prod / DIVISOR;
  assign wm_sat   = (quot > PROD_W'(WM_MAX)) ? WM_MAX : quot[WM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
      p1_valid <= 1'b0;
      p1_prod  <= '0;
      p1_set   <= '0;
      p1_field <= '0;
      req_q    <= 1'b0;
      commit_q <= 1'b0;
      done_q   <= 1'b0;
      sat_q    <= '0;
      minout_q <= '0;
      force_q  <= 1'b0;
    end else begin
      p1_valid <= accept;
      if (accept) begin
        p1_prod  <= PROD_W'(wr_ns) * PROD_W'(refclk_mhz);
        p1_set   <= wr_set;
        p1_field <= wr_field;
      end
      if (p1_valid && slot_ok(p1_set, p1_field))
        shadow_q[slot(p1_set, p1_field)] <= wm_sat;
      req_q    <= chg_req;
      commit_q <= commit;
      done_q   <= commit_q;
      if (commit) begin
        for (int i = 0; i < ENTRIES; i++) active_q[i] <= shadow_q[i];
        sat_q    <= SAT_W'(SAT_MULT) * SAT_W'(refclk_mhz);
        minout_q <= OUT_W'(MIN_OUT);
        force_q  <= stutter_off;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (slot_ok(rd_set, rd_field)) rd_data = active_q[slot(rd_set, rd_field)];
  end

  assign chg_done        = done_q;
  assign sat_level       = sat_q;
  assign min_outstanding = minout_q;
  assign sr_force_en     = force_q;
  assign sr_force_val    = 1'b0;

  // R5
  overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |=> wr_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chg_done |=> !chg_done);

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(chg_req && !req_q) |=>
      (!$stable(rd_set) || !$stable(rd_field) || $stable(rd_data)));

  // R11
  force_val_chk: assert property (@(posedge clk) disable iff (rst)
    !sr_force_val);
endmodule

// File: tb/wm_bank_tb_top.sv
module wm_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] refclk_mhz = 12'd100;
  logic        stutter_off = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_set = '0;
  logic [2:0]  wr_field = '0;
  logic [19:0] wr_ns = '0;
  logic        chg_req = 1'b0;
  logic [1:0]  rd_set = '0;
  logic [2:0]  rd_field = '0;
  logic        wr_ready, chg_done, sr_force_en, sr_force_val;
  logic [20:0] rd_data;
  logic [17:0] sat_level;
  logic [6:0]  min_outstanding;
  logic        n_ready, n_done, n_fen, n_fval;
  logic [20:0] n_rd;
  logic [17:0] n_sat;
  logic [6:0]  n_min;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  wm_bank dut_i (
    .clk, .rst, .refclk_mhz, .stutter_off, .wr_valid, .wr_ready, .wr_set,
    .wr_field, .wr_ns, .chg_req, .chg_done, .rd_set, .rd_field, .rd_data,
    .sat_level, .min_outstanding, .sr_force_en, .sr_force_val);

  wm_bank #(.HAS_SR(0)) dut_nosr_i (
    .clk, .rst, .refclk_mhz, .stutter_off, .wr_valid, .wr_ready(n_ready),
    .wr_set, .wr_field, .wr_ns, .chg_req, .chg_done(n_done), .rd_set,
    .rd_field, .rd_data(n_rd), .sat_level(n_sat), .min_outstanding(n_min),
    .sr_force_en(n_fen), .sr_force_val(n_fval));

  function automatic longint conv(input longint ns, input longint mhz);
    longint q;
    q = (ns * mhz) / 1000;
    return (q > 64'h1FFFFF) ? 64'h1FFFFF : q;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_wm(input int s, input int f, input int ns);
    @(negedge clk);
    wr_valid = 1'b1; wr_set = 2'(s); wr_field = 3'(f); wr_ns = 20'(ns);
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic commit();
    @(negedge clk); chg_req = 1'b1;
    @(negedge clk);
    @(negedge clk); chg_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input int s, input int f, output longint v, output longint vn);
    @(negedge clk);
    rd_set = 2'(s); rd_field = 3'(f);
    #1;
    v = rd_data; vn = n_rd;
  endtask

  task automatic t_reset();
    longint v, vn;
    check("R1 wr_ready", wr_ready, 1);
    check("R1 chg_done", chg_done, 0);
    check("R1 sat_level", sat_level, 0);
    check("R1 min_outstanding", min_outstanding, 0);
    check("R1 sr_force_en", sr_force_en, 0);
    for (int s = 0; s < 4; s++) begin
      rd(s, 4, v, vn); check("R1 active zero", v, 0);
    end
  endtask

  task automatic t_convert();
    longint v, vn;
    refclk_mhz = 12'd100;
    write_wm(0, 0, 1234);
    write_wm(1, 1, 999);
    write_wm(2, 4, 7);
    refclk_mhz = 12'd333;
    write_wm(3, 0, 54321);
    write_wm(0, 4, 0);
    commit();
    rd(0, 0, v, vn); check("R2 1234ns@100", v, conv(1234, 100));
    rd(1, 1, v, vn); check("R2 999ns@100 floor", v, conv(999, 100));
    rd(2, 4, v, vn); check("R2 7ns@100 to zero", v, 0);
    rd(3, 0, v, vn); check("R2 54321ns@333", v, conv(54321, 333));
    rd(0, 4, v, vn); check("R2 zero", v, 0);
  endtask

  task automatic t_saturate();
    longint v, vn;
    refclk_mhz = 12'd4095;
    write_wm(1, 0, 1048575);
    refclk_mhz = 12'd2000;
    write_wm(1, 4, 1048575);
    commit();
    rd(1, 0, v, vn); check("R3 clamp", v, 64'h1FFFFF);
    rd(1, 4, v, vn); check("R3 below limit", v, conv(1048575, 2000));
  endtask

  task automatic t_fields();
    longint v, vn;
    refclk_mhz = 12'd1000;
    for (int f = 0; f < 5; f++) write_wm(3, f, 100 + f);
    write_wm(2, 0, 555);
    commit();
    write_wm(1, 5, 999);
    write_wm(1, 7, 999);
    commit();
    for (int f = 0; f < 5; f++) begin
      rd(3, f, v, vn); check("R4 set D field map", v, 100 + f);
    end
    rd(2, 0, v, vn); check("R4 invalid field dropped", v, 555);
    rd(1, 5, v, vn); check("R4 invalid field reads 0", v, 0);
  endtask

  task automatic t_handshake();
    longint v, vn;
    refclk_mhz = 12'd1000;
    @(negedge clk);
    wr_valid = 1'b1; wr_set = 2'd0; wr_field = 3'd1; wr_ns = 20'd42;
    @(posedge clk); #1;
    check("R5 ready low after accept", wr_ready, 0);
    @(posedge clk); #1;
    check("R5 ready back", wr_ready, 1);
    @(negedge clk); wr_valid = 1'b0;
    @(negedge clk);
    rd(0, 1, v, vn); check("R6 staged not visible", v, 0);
    commit();
    rd(0, 1, v, vn); check("R5 value landed", v, 42);
  endtask

  task automatic t_commit();
    longint v, vn;
    refclk_mhz = 12'd1000;
    write_wm(2, 1, 77);
    rd(2, 1, v, vn);
    @(negedge clk); chg_req = 1'b1;
    @(negedge clk); #1;
    check("R8 done not with copy", chg_done, 0);
    check("R7 copy on edge", rd_data, 77);
    @(negedge clk); #1;
    check("R8 done pulse", chg_done, 1);
    write_wm(2, 1, 88);
    rd(2, 1, v, vn); check("R7 held high no recommit", v, 77);
    check("R8 done single", chg_done, 0);
    @(negedge clk); chg_req = 1'b0;
    commit();
    rd(2, 1, v, vn); check("R7 new edge commits", v, 88);
  endtask

  task automatic t_ctrl();
    refclk_mhz = 12'd100; stutter_off = 1'b1;
    commit();
    check("R10 sat_level", sat_level, 6000);
    check("R10 min_outstanding", min_outstanding, 68);
    check("R11 force_en", sr_force_en, 1);
    check("R11 force_val", sr_force_val, 0);
    refclk_mhz = 12'd250; stutter_off = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 held until commit", sat_level, 6000);
    check("R11 held until commit", sr_force_en, 1);
    commit();
    check("R10 recommit", sat_level, 15000);
    check("R11 cleared", sr_force_en, 0);
  endtask

  task automatic t_nosr();
    longint v, vn;
    refclk_mhz = 12'd1000;
    write_wm(0, 2, 300);
    write_wm(0, 3, 400);
    commit();
    rd(0, 2, v, vn);
    check("R9 sr enter present", v, 300);
    check("R9 sr enter absent reads 0", vn, 0);
    rd(0, 3, v, vn);
    check("R9 sr exit present", v, 400);
    check("R9 sr exit absent reads 0", vn, 0);
    rd(3, 4, v, vn);
    check("R9 other field kept", vn, 104);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_convert();
    t_saturate();
    t_fields();
    t_handshake();
    t_commit();
    t_ctrl();
    t_nosr();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule